// File: doc/BRIEF.md
# Nine-Bit Address-Filtering Serial Receiver

This block receives asynchronous serial frames that carry nine payload bits: eight data bits and a ninth bit that tags the frame. A ninth bit of one marks an address frame and a ninth bit of zero marks a data frame. It is meant for a bus where one controller talks to several listeners over a shared line. Each listener keeps its filter enable set while it waits to be addressed. Software reads each address frame, compares it with the listener's own 8-bit address and, on a match, clears the filter enable so that the data frames that follow reach it. Once the message has ended, software sets the enable again.

The receiver runs from a tick input at sixteen times the bit rate. It synchronizes the line and samples every bit at its midpoint. When the stop bit is sampled, it decides whether the frame is accepted. An accepted frame loads the byte register and the ninth-bit status bit and raises the receive interrupt flag. The flag stays set until software pulses the clear strobe. A filtered frame leaves every output untouched. A frame with a low stop bit raises only the framing-error flag.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, `rx_byte` is 0 and `rx_bit9`, `rx_irq`, `frame_err` and `overrun` are all 0.
- R2: A frame is a low start bit, then eight data bits sent least significant bit first, then the ninth bit, then one high stop bit. The line idles high. An accepted frame places the eight data bits in `rx_byte` and the ninth bit in `rx_bit9`.
- R3: The line passes through a two-flop synchronizer, and each bit is sampled every 16 `baud_tick` pulses at mid-bit. A low pulse that is already high again at the midpoint of the start bit is treated as a glitch. It changes no output.
- R4: While `mp_en` is 0, every frame with a high stop bit is accepted, whatever its ninth bit. It sets `rx_irq`.
- R5: While `mp_en` is 1, a frame whose ninth bit is 0 is dropped. It sets no flag and leaves `rx_byte` and `rx_bit9` unchanged. A frame whose ninth bit is 1 is accepted.
- R6: `mp_en` is evaluated only when the stop bit is sampled. The value it held earlier in the frame has no effect.
- R7: A frame with a low stop bit sets `frame_err`, does not set `rx_irq`, and leaves `rx_byte` and `rx_bit9` unchanged.
- R8: A one-cycle pulse on `irq_clr` clears `rx_irq`, `frame_err` and `overrun`. Without that pulse, all three flags hold their value.
- R9: When a frame is accepted while `rx_irq` is still 1, `rx_byte` and `rx_bit9` are overwritten with the new frame and `overrun` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idles high |
| mp_en | input | 1 | Filter enable: drop frames whose ninth bit is 0 |
| irq_clr | input | 1 | One-cycle strobe that clears the flags |
| rx_byte | output | 8 | Data bits of the last accepted frame |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| rx_irq | output | 1 | Receive interrupt flag |
| frame_err | output | 1 | Sticky flag: a stop bit was sampled low |
| overrun | output | 1 | Sticky flag: a frame was accepted while `rx_irq` was set |

## Verification
Most faults in the bit counter or the shift register show up in `rx_byte` or `rx_bit9` at the end of the first frame. They appear as shifted, swapped or lost bits, or as a ninth bit that lands in the data byte. A fault in the sampling phase or in the stop-bit decision shows up within one frame time. It appears either as a spurious `frame_err` or as a missing or extra `rx_irq`, and a change in `mp_en` during the frame exposes it. Flag-handling faults show up on the first clear strobe or on the second frame accepted without a clear, through `overrun`.

// File: rtl/mp_uart_rx_pkg.sv
// Shared types for the nine-bit address-filtering receiver.
package mp_uart_rx_pkg;

    // Receive sequencer states.
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

endpackage

// File: rtl/mp_uart_rx_sync.sv
// Line synchronizer.
// Brings the asynchronous serial input into the clock domain through a
// chain of STAGES flops. The chain resets to the idle (high) level, so a
// low line during reset is not mistaken for a start bit.
// Assumes STAGES >= 2.
module mp_uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d_in};
        end
    end

    assign q_out = chain[STAGES-1];

endmodule

// File: rtl/mp_uart_rx_framer.sv
// Frame sequencer.
// Detects a start bit and confirms it at its midpoint. It then samples
// FRAME_BITS payload bits, least significant first, once every OVS ticks,
// and finally samples the stop bit. When the stop bit is sampled, it emits
// a one-cycle done pulse together with the stop level and the payload.
// Assumes OVS is even and baud_tick is a single-cycle pulse.
module mp_uart_rx_framer
    import mp_uart_rx_pkg::*;
#(
    parameter int OVS        = 16,
    parameter int FRAME_BITS = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  line,
    output logic                  done,
    output logic                  stop_ok,
    output logic [FRAME_BITS-1:0] payload
);

    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(FRAME_BITS + 1);
    localparam int HALF  = OVS / 2;

    rx_state_t                 state;
    logic [CNT_W-1:0]          cnt;
    logic [IDX_W-1:0]          idx;
    logic [FRAME_BITS-1:0]     shreg;

    // Step through the frame one tick at a time and sample at mid-bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            done    <= 1'b0;
            stop_ok <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!line) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == CNT_W'(HALF - 1)) begin
                            cnt <= '0;
                            idx <= '0;
                            state <= line ? RX_IDLE : RX_BITS;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_BITS: begin
                        if (cnt == CNT_W'(OVS - 1)) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[FRAME_BITS-1:1]};
                            if (idx == IDX_W'(FRAME_BITS - 1)) begin
                                state <= RX_STOP;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == CNT_W'(OVS - 1)) begin
                            cnt     <= '0;
                            done    <= 1'b1;
                            stop_ok <= line;
                            state   <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    assign payload = shreg;

endmodule

// File: rtl/mp_uart_rx_accept.sv
// Acceptance filter and status flags.
// On each completed frame, decides whether to keep it. A frame with a low
// stop bit only sets the framing-error flag. A frame with a high stop bit
// is kept when the filter enable is low or the ninth bit is high. A kept
// frame loads the byte and the ninth bit and raises the interrupt flag,
// and it sets overrun when the interrupt flag was still set. The clear
// strobe drops all flags. A set in the same cycle wins over the clear.
module mp_uart_rx_accept #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              stop_ok,
    input  logic [DATA_W:0]   payload,
    input  logic              filt_en,
    input  logic              clr,
    output logic [DATA_W-1:0] byte_q,
    output logic              bit9_q,
    output logic              irq_q,
    output logic              ferr_q,
    output logic              ovr_q
);

    logic keep;
    logic bad_stop;

    // Acceptance decision for the frame that just ended.
    always_comb begin
        keep     = done && stop_ok && (!filt_en || payload[DATA_W]);
        bad_stop = done && !stop_ok;
    end

    // Load the data registers for a kept frame only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            bit9_q <= 1'b0;
        end else if (keep) begin
            byte_q <= payload[DATA_W-1:0];
            bit9_q <= payload[DATA_W];
        end
    end

    // Maintain the sticky flags; a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            ferr_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (keep)          irq_q <= 1'b1;
            else if (clr)      irq_q <= 1'b0;
            if (bad_stop)      ferr_q <= 1'b1;
            else if (clr)      ferr_q <= 1'b0;
            if (keep && irq_q) ovr_q <= 1'b1;
            else if (clr)      ovr_q <= 1'b0;
        end
    end

endmodule

// File: rtl/mp_uart_rx.sv
// Nine-bit address-filtering serial receiver (top).
// Chains the line synchronizer, the frame sequencer and the acceptance
// filter. Assumes baud_tick pulses at OVS times the bit rate and that
// software holds mp_en steady around the stop bit.
module mp_uart_rx #(
    parameter int DATA_W     = 8,
    parameter int OVS        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              rx_in,
    input  logic              mp_en,
    input  logic              irq_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              rx_irq,
    output logic              frame_err,
    output logic              overrun
);

    localparam int FRAME_BITS = DATA_W + 1;

    logic                  line_s;
    logic                  f_done;
    logic                  f_stop_ok;
    logic [FRAME_BITS-1:0] f_payload;
    logic                  f_bit9;

    assign f_bit9 = f_payload[FRAME_BITS-1];

    mp_uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_in),
        .q_out (line_s)
    );

    mp_uart_rx_framer #(.OVS(OVS), .FRAME_BITS(FRAME_BITS)) i_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .line    (line_s),
        .done    (f_done),
        .stop_ok (f_stop_ok),
        .payload (f_payload)
    );

    mp_uart_rx_accept #(.DATA_W(DATA_W)) i_accept (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (f_done),
        .stop_ok (f_stop_ok),
        .payload (f_payload),
        .filt_en (mp_en),
        .clr     (irq_clr),
        .byte_q  (rx_byte),
        .bit9_q  (rx_bit9),
        .irq_q   (rx_irq),
        .ferr_q  (frame_err),
        .ovr_q   (overrun)
    );

endmodule

// File: rtl/mp_uart_rx_chk.sv
// Property checker for mp_uart_rx, bound to every instance of the top.
module mp_uart_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mp_en,
    input logic              irq_clr,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_bit9,
    input logic              rx_irq,
    input logic              frame_err,
    input logic              overrun,
    input logic              f_done,
    input logic              f_stop_ok,
    input logic              f_bit9
);

    // R4: a good frame with the filter off raises the interrupt.
    a_r4_accept_all: assert property (@(posedge clk) disable iff (!rst_n)
        f_done && f_stop_ok && !mp_en |=> rx_irq);

    // R5: a data frame with the filter on changes nothing.
    a_r5_drop_data: assert property (@(posedge clk) disable iff (!rst_n)
        f_done && f_stop_ok && mp_en && !f_bit9
        |=> $stable(rx_byte) && $stable(rx_bit9) && !$rose(rx_irq));

    // R7: a low stop bit sets the framing error and loads nothing.
    a_r7_bad_stop: assert property (@(posedge clk) disable iff (!rst_n)
        f_done && !f_stop_ok
        |=> frame_err && $stable(rx_byte) && $stable(rx_bit9) && !$rose(rx_irq));

    // R8: a clear with no frame ending drops all flags.
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr && !f_done |=> !rx_irq && !frame_err && !overrun);

    // R9: overrun only rises while the interrupt was pending.
    a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_irq));

endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mp_en     (mp_en),
    .irq_clr   (irq_clr),
    .rx_byte   (rx_byte),
    .rx_bit9   (rx_bit9),
    .rx_irq    (rx_irq),
    .frame_err (frame_err),
    .overrun   (overrun),
    .f_done    (f_done),
    .f_stop_ok (f_stop_ok),
    .f_bit9    (f_bit9)
);

// File: tb/test_mp_uart_rx.sv
// Bench for mp_uart_rx: directed corner cases plus seeded random frames.
module test_mp_uart_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       mp_en = 1'b0;
    logic       irq_clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_bit9;
    logic       rx_irq;
    logic       frame_err;
    logic       overrun;

    int         n_chk = 0;
    int         n_bad = 0;
    logic [1:0] tdiv = '0;

    logic [7:0] e_byte = '0;
    logic       e_b9 = 1'b0;
    logic       e_irq = 1'b0;
    logic       e_fe = 1'b0;
    logic       e_ov = 1'b0;

    always #10 clk = ~clk;

    // Tick every third clock, updated at the rising edge.
    always @(posedge clk) begin
        tdiv      <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
        baud_tick <= (tdiv == 2'd2);
    end

    mp_uart_rx i_mp_uart_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .rx_in     (rx_in),
        .mp_en     (mp_en),
        .irq_clr   (irq_clr),
        .rx_byte   (rx_byte),
        .rx_bit9   (rx_bit9),
        .rx_irq    (rx_irq),
        .frame_err (frame_err),
        .overrun   (overrun)
    );

    function automatic logic accepts(input logic mp, input logic b9, input logic stop);
        return stop && (!mp || b9);
    endfunction

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!baud_tick);
        end
    endtask

    task automatic chk1(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk1(req, "rx_byte", rx_byte, e_byte);
        chk1(req, "rx_bit9", rx_bit9, e_b9);
        chk1(req, "rx_irq", rx_irq, e_irq);
        chk1(req, "frame_err", frame_err, e_fe);
        chk1(req, "overrun", overrun, e_ov);
    endtask

    task automatic clear_flags();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        e_irq = 1'b0;
        e_fe  = 1'b0;
        e_ov  = 1'b0;
    endtask

    // Send one frame; mp_early holds during the start bit, mp_late after it.
    task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop,
                              input logic mp_early, input logic mp_late);
        mp_en = mp_early;
        rx_in = 1'b0;
        wait_ticks(16);
        mp_en = mp_late;
        for (int i = 0; i < 8; i++) begin
            rx_in = d[i];
            wait_ticks(16);
        end
        rx_in = b9;
        wait_ticks(16);
        rx_in = stop;
        wait_ticks(stop ? 16 : 10);
        rx_in = 1'b1;
        wait_ticks(stop ? 6 : 24);
        if (!stop) begin
            e_fe = 1'b1;
        end else if (accepts(mp_late, b9, stop)) begin
            if (e_irq) e_ov = 1'b1;
            e_irq  = 1'b1;
            e_byte = d;
            e_b9   = b9;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2/R4: data frame, filter off, bit order.
        send_frame(8'hA5, 1'b0, 1'b1, 1'b0, 1'b0);
        check_all("R2");
        clear_flags();
        check_all("R8");
        send_frame(8'h01, 1'b1, 1'b1, 1'b0, 1'b0);
        check_all("R4");
        clear_flags();

        // R5: filter on drops a data frame, keeps an address frame.
        send_frame(8'h3C, 1'b0, 1'b1, 1'b1, 1'b1);
        check_all("R5");
        send_frame(8'h80, 1'b1, 1'b1, 1'b1, 1'b1);
        check_all("R5");
        clear_flags();

        // R6: only the value at the stop bit counts.
        send_frame(8'h5A, 1'b0, 1'b1, 1'b1, 1'b0);
        check_all("R6");
        clear_flags();
        send_frame(8'hC3, 1'b0, 1'b1, 1'b0, 1'b1);
        check_all("R6");

        // R3: start glitch is ignored.
        rx_in = 1'b0;
        wait_ticks(3);
        rx_in = 1'b1;
        wait_ticks(24);
        check_all("R3");

        // R7: low stop bit.
        send_frame(8'hFF, 1'b1, 1'b0, 1'b0, 1'b0);
        check_all("R7");
        clear_flags();
        check_all("R8");

        // R9: second accepted frame without a clear.
        send_frame(8'h11, 1'b0, 1'b1, 1'b0, 1'b0);
        send_frame(8'h22, 1'b1, 1'b1, 1'b0, 1'b0);
        check_all("R9");
        wait_ticks(40);
        check_all("R8");
        clear_flags();

        // Random mix of frames, filter settings and clears.
        for (int k = 0; k < 40; k++) begin
            logic [7:0] d;
            logic       b9, stop, mpe, mpl;
            d    = 8'($urandom);
            b9   = 1'($urandom);
            stop = ($urandom % 8) != 0;
            mpe  = 1'($urandom);
            mpl  = 1'($urandom);
            if (($urandom % 3) == 0) clear_flags();
            send_frame(d, b9, stop, mpe, mpl);
            check_all("R2 R5 R9 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule